// File: doc/BRIEF.md
# Twisted-Pair Link Pulse Generator and Link Integrity Monitor

This block sits beside a 10BASE-T transceiver. While the transmitter has no frame to send, it asks the line driver for a short link pulse at a fixed idle interval. The remote station learns from these pulses that the cable is connected. The default pulse is 100 ns wide and the default interval is 16 ms. Any transmission suspends the pulses and restarts the idle interval from the end of that frame.

The same block watches the other direction. Received link pulses and receive activity keep the link alive. Link pulses that arrive closer together than a minimum spacing (2 ms by default) are treated as noise and discarded. If neither an accepted pulse nor receive activity is seen for the loss time (100 ms by default), the block raises a fail flag that the surrounding logic uses to inhibit transmit, receive and collision detection. A failed link comes back after a set number of consecutive accepted pulses (2 by default), or at once when receive activity is seen. A good-link output is the inverse of the fail flag and can drive an indicator LED directly.

A configuration input bypasses the integrity check: while it is set, the link is treated as good. Every time constant is derived from a clock-frequency parameter.

Top module: `lnk_pulse_monitor`

## Requirements
- R1: Each link pulse holds `lp_req` high for exactly PULSE cycles. PULSE is CLK_HZ × PULSE_NS / 10^9, with a minimum of 1.
- R2: With `tx_active` low, `lp_req` rises on the PERIOD-th rising edge after reset release, or after the last edge that sampled `tx_active` high. While idle, successive pulse starts are PERIOD cycles apart. PERIOD is CLK_HZ × PERIOD_US / 10^6.
- R3: From the edge that samples `tx_active` high, `lp_req` is low, including when the transmitter starts in the middle of a pulse.
- R4: During and straight after reset, `link_fail` is 1, `good_led` is 0 and `lp_req` is 0.
- R5: While the link is good, `link_fail` rises on the LOSS-th edge after the last edge that sampled an accepted pulse, receive activity, or the bypass bit. LOSS is CLK_HZ × LOSS_US / 10^6.
- R6: A strobe on `rx_lp_strobe` is accepted only if it is sampled at least GAP edges after the previously accepted one. The first strobe after reset is always accepted. A rejected strobe neither counts toward restore nor refreshes the loss timer. GAP is CLK_HZ × GAP_US / 10^6.
- R7: In the fail state, `link_fail` clears on the edge that samples the RESTORE_PULSES-th consecutive accepted pulse. If the loss time passes without an accepted pulse, the count starts again.
- R8: An edge that samples `rx_activity` high clears `link_fail` and restarts the loss timer.
- R9: While `cfg_test_off` is 1, `link_fail` is 0 from the next edge on. The loss timer restarts from the last edge that sampled the bit high.
- R10: `good_led` is always the inverse of `link_fail`.
- R11: If an accepted pulse is sampled on the same edge at which the loss time would expire, the link stays good and the loss timer restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, frequency CLK_HZ |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_active | input | 1 | Transmitter is sending a frame |
| rx_lp_strobe | input | 1 | One-cycle strobe per link pulse detected on the receive pair |
| rx_activity | input | 1 | Receive data activity is present |
| cfg_test_off | input | 1 | 1 bypasses the integrity check (link treated as good) |
| lp_req | output | 1 | Request to the line driver to send a link pulse |
| good_led | output | 1 | High while the link is good |
| link_fail | output | 1 | High while the link has failed; inhibits the data path |

## Verification
The loss timer's expiry and the arrival of an accepted link pulse can land on the same clock edge. If the block gave priority to the expiry, it would drop a link that is still alive. The bench provokes this by bringing the link up with one cycle of receive activity, waiting exactly LOSS−1 cycles, and then strobing a pulse so that it is sampled on the expiry edge. It then checks that `link_fail` stays low, and that the failure arrives a full LOSS cycles after that pulse rather than at the original deadline.

// File: rtl/lnk_pkg.sv
`timescale 1ns/1ps
package lnk_pkg;

    typedef enum logic {
        LNK_DOWN = 1'b0,
        LNK_UP   = 1'b1
    } lnk_state_t;

    // Convert a duration to clock cycles, never returning less than one.
    function automatic int unsigned lnk_cycles(
        input longint unsigned hz,
        input longint unsigned amount,
        input longint unsigned units_per_sec
    );
        longint unsigned c;
        c = (hz * amount) / units_per_sec;
        if (c == 64'd0) c = 64'd1;
        return c[31:0];
    endfunction

endpackage

// File: rtl/lnk_pulse_gen.sv
`timescale 1ns/1ps
module lnk_pulse_gen #(
    parameter int unsigned PERIOD_CYC = 400,
    parameter int unsigned PULSE_CYC  = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_active,
    output logic lp_req
);

    localparam int CW = $clog2(PERIOD_CYC + 1);
    localparam int PW = $clog2(PULSE_CYC + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(PERIOD_CYC - 1);
    localparam logic [PW-1:0] PLS_LAST = PW'(PULSE_CYC - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [PW-1:0] pcnt;
        logic          lp;
    } gen_t;

    gen_t gen_d, gen_q;
    logic wrap;

    always_comb begin
        gen_d = gen_q;
        wrap  = 1'b0;
        if (tx_active) begin
            gen_d.cnt  = '0;
            gen_d.pcnt = '0;
            gen_d.lp   = 1'b0;
        end else begin
            wrap = (gen_q.cnt == CNT_LAST);
            if (wrap) begin
                gen_d.cnt  = '0;
                gen_d.pcnt = '0;
                gen_d.lp   = 1'b1;
            end else begin
                gen_d.cnt = gen_q.cnt + 1'b1;
                if (gen_q.lp) begin
                    if (gen_q.pcnt == PLS_LAST) begin
                        gen_d.lp = 1'b0;
                    end else begin
                        gen_d.pcnt = gen_q.pcnt + 1'b1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gen_q <= '0;
        end else begin
            gen_q <= gen_d;
        end
    end

    assign lp_req = gen_q.lp;

    // R3: a transmitting cycle silences the pulse output
    p_tx_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_active |=> !lp_req);

    // R2: a pulse begins only when the idle interval has run out
    p_start_on_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lp_req) |-> ($past(gen_q.cnt) == CNT_LAST));

    // R1: a pulse ends early only because of a transmission
    p_width_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(lp_req) && !$past(tx_active)) |-> ($past(gen_q.pcnt) == PLS_LAST));

endmodule

// File: rtl/lnk_pulse_qual.sv
`timescale 1ns/1ps
module lnk_pulse_qual #(
    parameter int unsigned GAP_CYC = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_lp_strobe,
    output logic pulse_ok
);

    localparam int GW = $clog2(GAP_CYC + 1);
    localparam logic [GW-1:0] GAP_LAST = GW'(GAP_CYC - 1);

    typedef struct packed {
        logic [GW-1:0] gap;
    } qual_t;

    qual_t qual_d, qual_q;

    assign pulse_ok = rx_lp_strobe && (qual_q.gap == GAP_LAST);

    always_comb begin
        qual_d = qual_q;
        if (pulse_ok) begin
            qual_d.gap = '0;
        end else if (qual_q.gap != GAP_LAST) begin
            qual_d.gap = qual_q.gap + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            qual_q.gap <= GAP_LAST;
        end else begin
            qual_q <= qual_d;
        end
    end

    // R6: two accepted pulses are never on neighbouring edges when spacing applies
    p_spacing_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((GAP_CYC > 1) && pulse_ok) |=> !pulse_ok);

endmodule

// File: rtl/lnk_integrity.sv
`timescale 1ns/1ps
module lnk_integrity
    import lnk_pkg::*;
#(
    parameter int unsigned LOSS_CYC       = 2000,
    parameter int unsigned RESTORE_PULSES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pulse_ok,
    input  logic rx_activity,
    input  logic cfg_test_off,
    output logic link_fail
);

    localparam int SW = $clog2(LOSS_CYC + 1);
    localparam int VW = $clog2(RESTORE_PULSES + 1);
    localparam logic [SW-1:0] SIL_LAST = SW'(LOSS_CYC - 1);
    localparam logic [VW-1:0] RST_LAST = VW'(RESTORE_PULSES - 1);

    typedef struct packed {
        lnk_state_t    st;
        logic [SW-1:0] silent;
        logic [VW-1:0] vcnt;
    } mon_t;

    mon_t mon_d, mon_q;

    always_comb begin
        mon_d = mon_q;
        if (cfg_test_off) begin
            mon_d.st     = LNK_UP;
            mon_d.silent = '0;
            mon_d.vcnt   = '0;
        end else if (mon_q.st == LNK_DOWN) begin
            if (rx_activity) begin
                mon_d.st     = LNK_UP;
                mon_d.silent = '0;
                mon_d.vcnt   = '0;
            end else if (pulse_ok) begin
                mon_d.silent = '0;
                if (mon_q.vcnt == RST_LAST) begin
                    mon_d.st   = LNK_UP;
                    mon_d.vcnt = '0;
                end else begin
                    mon_d.vcnt = mon_q.vcnt + 1'b1;
                end
            end else if (mon_q.silent == SIL_LAST) begin
                mon_d.silent = '0;
                mon_d.vcnt   = '0;
            end else begin
                mon_d.silent = mon_q.silent + 1'b1;
            end
        end else begin
            if (rx_activity || pulse_ok) begin
                mon_d.silent = '0;
            end else if (mon_q.silent == SIL_LAST) begin
                mon_d.st     = LNK_DOWN;
                mon_d.silent = '0;
                mon_d.vcnt   = '0;
            end else begin
                mon_d.silent = mon_q.silent + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mon_q.st     <= LNK_DOWN;
            mon_q.silent <= '0;
            mon_q.vcnt   <= '0;
        end else begin
            mon_q <= mon_d;
        end
    end

    assign link_fail = (mon_q.st == LNK_DOWN);

    // R5: a failure is entered only after a silent, unbypassed cycle
    p_loss_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(link_fail) |-> $past(!rx_activity && !pulse_ok && !cfg_test_off));

    // R7: with no pulse, activity or bypass, a failed link stays failed
    p_hold_fail_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (link_fail && !rx_activity && !pulse_ok && !cfg_test_off) |=> link_fail);

    // R8: receive activity always leaves the link good
    p_activity_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_activity |=> !link_fail);

    // R9: the bypass bit forces a good link
    p_bypass_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_test_off |=> !link_fail);

    // R11: an accepted pulse on a good link keeps it good
    p_refresh_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!link_fail && pulse_ok) |=> !link_fail);

endmodule

// File: rtl/lnk_pulse_monitor.sv
`timescale 1ns/1ps
module lnk_pulse_monitor #(
    parameter int unsigned CLK_HZ         = 200_000_000,
    parameter int unsigned PULSE_NS       = 100,
    parameter int unsigned PERIOD_US      = 16_000,
    parameter int unsigned LOSS_US        = 100_000,
    parameter int unsigned GAP_US         = 2_000,
    parameter int unsigned RESTORE_PULSES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_active,
    input  logic rx_lp_strobe,
    input  logic rx_activity,
    input  logic cfg_test_off,
    output logic lp_req,
    output logic good_led,
    output logic link_fail
);

    localparam int unsigned PULSE_CYC =
        lnk_pkg::lnk_cycles(64'(CLK_HZ), 64'(PULSE_NS), 64'd1_000_000_000);
    localparam int unsigned PERIOD_CYC =
        lnk_pkg::lnk_cycles(64'(CLK_HZ), 64'(PERIOD_US), 64'd1_000_000);
    localparam int unsigned LOSS_CYC =
        lnk_pkg::lnk_cycles(64'(CLK_HZ), 64'(LOSS_US), 64'd1_000_000);
    localparam int unsigned GAP_CYC =
        lnk_pkg::lnk_cycles(64'(CLK_HZ), 64'(GAP_US), 64'd1_000_000);

    logic pulse_ok;
    logic fail_w;

    lnk_pulse_gen #(
        .PERIOD_CYC (PERIOD_CYC),
        .PULSE_CYC  (PULSE_CYC)
    ) u_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_active (tx_active),
        .lp_req    (lp_req)
    );

    lnk_pulse_qual #(
        .GAP_CYC (GAP_CYC)
    ) u_qual (
        .clk          (clk),
        .rst_n        (rst_n),
        .rx_lp_strobe (rx_lp_strobe),
        .pulse_ok     (pulse_ok)
    );

    lnk_integrity #(
        .LOSS_CYC       (LOSS_CYC),
        .RESTORE_PULSES (RESTORE_PULSES)
    ) u_mon (
        .clk          (clk),
        .rst_n        (rst_n),
        .pulse_ok     (pulse_ok),
        .rx_activity  (rx_activity),
        .cfg_test_off (cfg_test_off),
        .link_fail    (fail_w)
    );

    assign link_fail = fail_w;
    assign good_led  = !fail_w;

endmodule

// File: tb/lnk_pulse_monitor_test.sv
`timescale 1ns/1ps
module lnk_pulse_monitor_test;

    localparam int PULSE   = 20;    // 200 MHz * 100 ns
    localparam int PERIOD  = 400;   // 200 MHz * 2 us
    localparam int LOSS    = 2000;  // 200 MHz * 10 us
    localparam int GAP     = 200;   // 200 MHz * 1 us

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_active = 1'b0;
    logic rx_lp_strobe = 1'b0;
    logic rx_activity = 1'b0;
    logic cfg_test_off = 1'b0;
    logic lp_req, good_led, link_fail;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    lnk_pulse_monitor #(
        .CLK_HZ (200_000_000), .PULSE_NS (100), .PERIOD_US (2),
        .LOSS_US (10), .GAP_US (1), .RESTORE_PULSES (2)
    ) uut (
        .clk (clk), .rst_n (rst_n), .tx_active (tx_active),
        .rx_lp_strobe (rx_lp_strobe), .rx_activity (rx_activity),
        .cfg_test_off (cfg_test_off), .lp_req (lp_req),
        .good_led (good_led), .link_fail (link_fail)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; tx_active = 1'b0; rx_lp_strobe = 1'b0;
        rx_activity = 1'b0; cfg_test_off = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_lp();
        rx_lp_strobe = 1'b1;
        @(negedge clk);
        rx_lp_strobe = 1'b0;
    endtask

    task automatic send_act();
        rx_activity = 1'b1;
        @(negedge clk);
        rx_activity = 1'b0;
    endtask

    task automatic wait_rise(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!lp_req && n < 3000);
    endtask

    // R4, R1, R2, R10
    task automatic t_reset_and_period();
        int n, w, n2;
        do_reset();
        chk("R4 link_fail after reset", int'(link_fail), 1);
        chk("R4 lp_req after reset", int'(lp_req), 0);
        chk("R10 good_led after reset", int'(good_led), 0);
        wait_rise(n);
        chk("R2 first pulse delay", n, PERIOD);
        w = 0;
        while (lp_req && w < 1000) begin
            w++;
            @(negedge clk);
        end
        chk("R1 pulse width", w, PULSE);
        wait_rise(n2);
        chk("R2 pulse spacing", w + n2, PERIOD);
    endtask

    // R3, R2
    task automatic t_tx_block();
        int seen, n;
        do_reset();
        tx_active = 1'b1;
        seen = 0;
        for (int i = 0; i < 2 * PERIOD; i++) begin
            @(negedge clk);
            if (lp_req) seen++;
        end
        chk("R3 pulses during transmit", seen, 0);
        tx_active = 1'b0;
        wait_rise(n);
        chk("R2 delay after transmit ends", n, PERIOD);
        idle(3);
        tx_active = 1'b1;
        @(negedge clk);
        chk("R3 pulse cut by transmit", int'(lp_req), 0);
        tx_active = 1'b0;
    endtask

    // R6, R7, R5, R10
    task automatic t_pulses_and_loss();
        do_reset();
        send_lp();
        chk("R7 one pulse not enough", int'(link_fail), 1);
        idle(GAP - 2);
        send_lp();  // GAP-1 after the first: rejected
        chk("R6 early pulse ignored", int'(link_fail), 1);
        send_lp();  // exactly GAP after the first: accepted
        chk("R7 restored by second pulse", int'(link_fail), 0);
        chk("R10 good_led when restored", int'(good_led), 1);
        idle(9);
        send_lp();  // 10 after the last accepted: rejected, no refresh
        idle(LOSS - 11);
        chk("R5 good just before loss", int'(link_fail), 0);
        idle(1);
        chk("R5 R6 fail at loss time", int'(link_fail), 1);
        chk("R10 good_led on failure", int'(good_led), 0);
    endtask

    // R8, R5
    task automatic t_activity();
        do_reset();
        send_act();
        chk("R8 activity restores link", int'(link_fail), 0);
        idle(LOSS - 1);
        chk("R8 activity restarts loss timer", int'(link_fail), 0);
        idle(1);
        chk("R5 fail after activity stops", int'(link_fail), 1);
    endtask

    // R11
    task automatic t_same_edge();
        do_reset();
        send_act();
        idle(LOSS - 1);
        send_lp();  // sampled on the expiry edge
        chk("R11 pulse on expiry edge keeps link", int'(link_fail), 0);
        idle(LOSS - 1);
        chk("R11 timer restarted by pulse", int'(link_fail), 0);
        idle(1);
        chk("R11 fail one loss after pulse", int'(link_fail), 1);
    endtask

    // R9
    task automatic t_bypass();
        int cnt;
        do_reset();
        cfg_test_off = 1'b1;
        @(negedge clk);
        chk("R9 bypass forces good", int'(link_fail), 0);
        cnt = 0;
        for (int i = 0; i < 3 * LOSS; i++) begin
            @(negedge clk);
            if (link_fail) cnt++;
        end
        chk("R9 no failure while bypassed", cnt, 0);
        cfg_test_off = 1'b0;
        idle(LOSS - 1);
        chk("R9 good until loss after bypass", int'(link_fail), 0);
        idle(1);
        chk("R9 fail after bypass cleared", int'(link_fail), 1);
    endtask

    initial begin
        t_reset_and_period();
        t_tx_block();
        t_pulses_and_loss();
        t_activity();
        t_same_edge();
        t_bypass();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: got %0d expected %0d", 150000, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule